// File: doc/BRIEF.md
# Message Object Transfer Engine

This block moves the contents of one message object between a set of interface registers that the CPU can load and a small message object store held inside the block. Each object carries five field groups: the acceptance mask word, the arbitration word, a 16-bit control word and two 32-bit payload words. A single 32-bit command word starts a transfer. The command gives the direction, one enable per field group, two flag actions and the number of the object to address. Field groups that are not enabled are left exactly as they were, on both sides.

Every transfer is a read-modify-write of the addressed entry in three cycles: the entry is read, the new entry and the new interface contents are formed, and the entry is written back. The cycle count does not depend on how many groups are enabled. Flag side effects ride on the same transfer. A read may clear the object's pending-interrupt and new-data flags. A write may force the transmit-request and new-data flags on. When a read clears flags, the interface control word receives the flag values from before the clear. While a transfer runs, `busy` is high and further command words are dropped.

The CPU loads the interface registers one group at a time with a group select. Object numbers run from 0 to NUM_OBJ-1. A command that names a number outside that range is dropped.

Top module: `msg_xfer_engine`

## Requirements
- R1: After reset, `busy` is 0, `cmd_rdata` is 0, all five interface register groups are 0, and every stored object is all zero.
- R2: A command written while `busy` is 0 and with an object number (bits 7:0) below NUM_OBJ is accepted at that clock edge. `busy` is then high for exactly 3 cycles, and `cmd_rdata` returns the accepted word with bits 31:24 and 15:8 forced to zero.
- R3: A command written while `busy` is 1, or one that names object NUM_OBJ or above, is dropped: `busy`, `cmd_rdata` and the stored objects are not affected.
- R4: When bit 23 is 1 (write), each group whose enable is set is copied from the interface registers into the addressed object: bit 22 mask, bit 21 arbitration, bit 20 control, bit 17 payload word A, bit 16 payload word B. Groups whose enable is clear keep their stored value.
- R5: When bit 23 is 0 (read), each enabled group is copied from the addressed object into the interface registers. Interface groups that are not enabled keep their value, and the object keeps all of its fields except the flags named in R6.
- R6: On a read, bit 19 clears the object's pending-interrupt flag (control bit 9) and bit 18 clears its new-data flag (control bit 10). If the control group is also enabled, the interface control word receives the flag values from before the clear.
- R7: On a write, bit 18 sets the object's transmit-request flag (control bit 8) and new-data flag (control bit 10) to 1, whatever the interface control word holds. The other control bits follow the control group transfer.
- R8: On a write, bit 19 has no effect. The stored pending-interrupt flag changes only through the control group transfer.
- R9: On a read, the interface registers hold the transferred values by the first cycle in which `busy` is 0 again.
- R10: An interface register write loads `ifs_wdata` into the group picked by `ifs_sel`: 0 mask, 1 arbitration, 2 control (low 16 bits), 3 payload A, 4 payload B. Select values 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Last accepted command, reserved bits zero |
| busy | output | 1 | High while a transfer runs |
| ifs_wr | input | 1 | Interface register write strobe |
| ifs_sel | input | 3 | Interface group select |
| ifs_wdata | input | 32 | Interface register write data |
| if_mask | output | 32 | Interface mask group |
| if_arb | output | 32 | Interface arbitration group |
| if_ctrl | output | 16 | Interface control group |
| if_data_a | output | 32 | Interface payload word A |
| if_data_b | output | 32 | Interface payload word B |

## Verification
Two functions can fall in the same cycle. The first is the flag clear in the object together with the read-back of those same flags into the interface control word. The second is a new command arriving in the cycle after one was accepted, which must be dropped. The bench provokes the first by setting the transmit-request and new-data flags with a write, then reading with both clear actions and the control group enabled. The pre-clear word is expected in the interface, and a second read must show the flags cleared. The second is provoked by holding the command strobe for two cycles with a different word, and is judged through `cmd_rdata` and by reading back the object the dropped command named.

// File: rtl/msg_xfer_pkg.sv
package msg_xfer_pkg;

    localparam int GRP_W = 32;
    localparam int CTL_W = 16;
    localparam int CMD_W = 32;
    localparam int NUM_W = 8;
    localparam int SEL_W = 3;

    // command word bit positions (decoded by the sequencer)
    localparam int B_DIR    = 23;
    localparam int B_MASK   = 22;
    localparam int B_ARB    = 21;
    localparam int B_CTRL   = 20;
    localparam int B_CLRINT = 19;
    localparam int B_TXND   = 18;
    localparam int B_DA     = 17;
    localparam int B_DB     = 16;

    // flag positions inside the control group
    localparam int F_TXRQ = 8;
    localparam int F_INTP = 9;
    localparam int F_NDAT = 10;

    // interface group selects
    localparam logic [SEL_W-1:0] SEL_MASK = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ARB  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DA   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_DB   = 3'd4;

    typedef struct packed {
        logic [GRP_W-1:0] mask;
        logic [GRP_W-1:0] arb;
        logic [CTL_W-1:0] ctrl;
        logic [GRP_W-1:0] data_a;
        logic [GRP_W-1:0] data_b;
    } obj_t;

    typedef struct packed {
        logic             dir_wr;
        logic             acc_mask;
        logic             acc_arb;
        logic             acc_ctrl;
        logic             clr_int;
        logic             tx_nd;
        logic             acc_da;
        logic             acc_db;
        logic [NUM_W-1:0] num;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_MRG  = 2'd2,
        ST_WB   = 2'd3
    } xfer_st_e;

    typedef struct packed {
        xfer_st_e st;
        cmd_t     cmd;
    } seq_t;

    function automatic cmd_t cmd_decode(input logic [CMD_W-1:0] w);
        cmd_t c;
        c.dir_wr   = w[B_DIR];
        c.acc_mask = w[B_MASK];
        c.acc_arb  = w[B_ARB];
        c.acc_ctrl = w[B_CTRL];
        c.clr_int  = w[B_CLRINT];
        c.tx_nd    = w[B_TXND];
        c.acc_da   = w[B_DA];
        c.acc_db   = w[B_DB];
        c.num      = w[NUM_W-1:0];
        return c;
    endfunction

    function automatic logic [CMD_W-1:0] cmd_encode(input cmd_t c);
        logic [CMD_W-1:0] w;
        w = '0;
        w[B_DIR]       = c.dir_wr;
        w[B_MASK]      = c.acc_mask;
        w[B_ARB]       = c.acc_arb;
        w[B_CTRL]      = c.acc_ctrl;
        w[B_CLRINT]    = c.clr_int;
        w[B_TXND]      = c.tx_nd;
        w[B_DA]        = c.acc_da;
        w[B_DB]        = c.acc_db;
        w[NUM_W-1:0]   = c.num;
        return w;
    endfunction

endpackage

// File: rtl/msg_xfer_seq.sv
module msg_xfer_seq
    import msg_xfer_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic             busy,
    output xfer_st_e         st,
    output cmd_t             cmd,
    output logic [CMD_W-1:0] cmd_rdata
);

    localparam logic [NUM_W:0] NUM_LIM = (NUM_W+1)'(NUM_OBJ);

    seq_t seq_d, seq_q;
    logic num_ok;
    logic accept;
    logic unused_cmd_bits;

    assign unused_cmd_bits = ^{cmd_wdata[CMD_W-1:B_DIR+1], cmd_wdata[B_DB-1:NUM_W]};
    assign num_ok = ({1'b0, cmd_wdata[NUM_W-1:0]} < NUM_LIM);
    assign accept = (seq_q.st == ST_IDLE) && cmd_wr && num_ok;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (accept) begin
                    seq_d.st  = ST_RD;
                    seq_d.cmd = cmd_decode(cmd_wdata);
                end
            end
            ST_RD:   seq_d.st = ST_MRG;
            ST_MRG:  seq_d.st = ST_WB;
            ST_WB:   seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign st        = seq_q.st;
    assign cmd       = seq_q.cmd;
    assign busy      = (seq_q.st != ST_IDLE);
    assign cmd_rdata = cmd_encode(seq_q.cmd);

    // R2: an eligible command raises busy on the next cycle
    a_r2_accept_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && ({1'b0, cmd_wdata[NUM_W-1:0]} < NUM_LIM)) |=> busy);

    // R2: read phase is always followed by the merge phase
    a_r2_read_then_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RD) |=> (st == ST_MRG));

    // R2: write-back is the last busy cycle
    a_r2_wb_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WB) |=> !busy);

    // R3: the held command cannot change while a transfer runs
    a_r3_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_rdata));

    // R3: an out-of-range object number never starts a transfer
    a_r3_bad_num_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_wr && ({1'b0, cmd_wdata[NUM_W-1:0]} >= NUM_LIM)) |=> !busy);

endmodule

// File: rtl/msg_obj_store.sv
module msg_obj_store
    import msg_xfer_pkg::*;
#(
    parameter int NUM_OBJ = 32,
    parameter int AW      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    output obj_t          rd_obj,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  obj_t          wr_obj
);

    obj_t mem_d [NUM_OBJ];
    obj_t mem_q [NUM_OBJ];
    obj_t rd_d, rd_q;

    always_comb begin
        mem_d = mem_q;
        rd_d  = rd_q;
        if (rd_en) begin
            rd_d = mem_q[rd_idx];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_obj;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_OBJ; i++) begin
                mem_q[i] <= '0;
            end
            rd_q <= '0;
        end else begin
            mem_q <= mem_d;
            rd_q  <= rd_d;
        end
    end

    assign rd_obj = rd_q;

    // R4: a write-back lands in the addressed entry
    a_r4_wb_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_idx)] == $past(wr_obj)));

endmodule

// File: rtl/msg_xfer_merge.sv
module msg_xfer_merge
    import msg_xfer_pkg::*;
(
    input  cmd_t cmd,
    input  obj_t obj_old,
    input  obj_t ifs,
    output obj_t obj_new,
    output obj_t if_new
);

    always_comb begin
        obj_new = obj_old;
        if_new  = ifs;
        if (cmd.dir_wr) begin
            if (cmd.acc_mask) obj_new.mask   = ifs.mask;
            if (cmd.acc_arb)  obj_new.arb    = ifs.arb;
            if (cmd.acc_ctrl) obj_new.ctrl   = ifs.ctrl;
            if (cmd.acc_da)   obj_new.data_a = ifs.data_a;
            if (cmd.acc_db)   obj_new.data_b = ifs.data_b;
            if (cmd.tx_nd) begin
                obj_new.ctrl[F_TXRQ] = 1'b1;
                obj_new.ctrl[F_NDAT] = 1'b1;
            end
        end else begin
            if (cmd.acc_mask) if_new.mask   = obj_old.mask;
            if (cmd.acc_arb)  if_new.arb    = obj_old.arb;
            if (cmd.acc_ctrl) if_new.ctrl   = obj_old.ctrl;
            if (cmd.acc_da)   if_new.data_a = obj_old.data_a;
            if (cmd.acc_db)   if_new.data_b = obj_old.data_b;
            if (cmd.clr_int)  obj_new.ctrl[F_INTP] = 1'b0;
            if (cmd.tx_nd)    obj_new.ctrl[F_NDAT] = 1'b0;
        end
    end

    always_comb begin
        // R5: a read never alters the stored payload, mask or arbitration
        if (!cmd.dir_wr) begin
            a_r5_read_keeps_fields: assert (obj_new.mask == obj_old.mask &&
                                             obj_new.arb == obj_old.arb &&
                                             obj_new.data_a == obj_old.data_a &&
                                             obj_new.data_b == obj_old.data_b);
        end
        // R6: read-back of control carries the pre-clear flags
        if (!cmd.dir_wr && cmd.acc_ctrl) begin
            a_r6_preclear_readback: assert (if_new.ctrl == obj_old.ctrl);
        end
        // R7: forced transmit request and new data on a write
        if (cmd.dir_wr && cmd.tx_nd) begin
            a_r7_flags_forced: assert (obj_new.ctrl[F_TXRQ] && obj_new.ctrl[F_NDAT]);
        end
        // R8: pending interrupt moves on a write only with the control group
        if (cmd.dir_wr && !cmd.acc_ctrl) begin
            a_r8_intp_only_ctrl: assert (obj_new.ctrl[F_INTP] == obj_old.ctrl[F_INTP]);
        end
    end

endmodule

// File: rtl/msg_if_regs.sv
module msg_if_regs
    import msg_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [SEL_W-1:0] cpu_sel,
    input  logic [GRP_W-1:0] cpu_wdata,
    input  logic             load_en,
    input  obj_t             load_obj,
    output obj_t             if_obj
);

    obj_t if_d, if_q;

    always_comb begin
        if_d = if_q;
        if (cpu_wr) begin
            case (cpu_sel)
                SEL_MASK: if_d.mask   = cpu_wdata;
                SEL_ARB:  if_d.arb    = cpu_wdata;
                SEL_CTRL: if_d.ctrl   = cpu_wdata[CTL_W-1:0];
                SEL_DA:   if_d.data_a = cpu_wdata;
                SEL_DB:   if_d.data_b = cpu_wdata;
                default:  if_d = if_q;
            endcase
        end
        if (load_en) begin
            if_d = load_obj;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_q <= '0;
        end else begin
            if_q <= if_d;
        end
    end

    assign if_obj = if_q;

    // R10: an unused select leaves every group untouched
    a_r10_bad_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_sel > SEL_DB) && !load_en) |=> $stable(if_q));

endmodule

// File: rtl/msg_xfer_engine.sv
module msg_xfer_engine
    import msg_xfer_pkg::*;
#(
    parameter int NUM_OBJ = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic [CMD_W-1:0] cmd_rdata,
    output logic             busy,
    input  logic             ifs_wr,
    input  logic [SEL_W-1:0] ifs_sel,
    input  logic [GRP_W-1:0] ifs_wdata,
    output logic [GRP_W-1:0] if_mask,
    output logic [GRP_W-1:0] if_arb,
    output logic [CTL_W-1:0] if_ctrl,
    output logic [GRP_W-1:0] if_data_a,
    output logic [GRP_W-1:0] if_data_b
);

    localparam int AW = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1;

    xfer_st_e st;
    cmd_t     cmd;
    obj_t     rd_obj;
    obj_t     if_obj;
    obj_t     obj_new;
    obj_t     if_new;
    obj_t     wb_d, wb_q;

    msg_xfer_seq #(.NUM_OBJ(NUM_OBJ)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_wdata (cmd_wdata),
        .busy      (busy),
        .st        (st),
        .cmd       (cmd),
        .cmd_rdata (cmd_rdata)
    );

    msg_obj_store #(.NUM_OBJ(NUM_OBJ), .AW(AW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (st == ST_RD),
        .rd_idx (cmd.num[AW-1:0]),
        .rd_obj (rd_obj),
        .wr_en  (st == ST_WB),
        .wr_idx (cmd.num[AW-1:0]),
        .wr_obj (wb_q)
    );

    msg_xfer_merge u_merge (
        .cmd     (cmd),
        .obj_old (rd_obj),
        .ifs     (if_obj),
        .obj_new (obj_new),
        .if_new  (if_new)
    );

    msg_if_regs u_ifr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (ifs_wr),
        .cpu_sel   (ifs_sel),
        .cpu_wdata (ifs_wdata),
        .load_en   ((st == ST_MRG) && !cmd.dir_wr),
        .load_obj  (if_new),
        .if_obj    (if_obj)
    );

    always_comb begin
        wb_d = wb_q;
        if (st == ST_MRG) begin
            wb_d = obj_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign if_mask   = if_obj.mask;
    assign if_arb    = if_obj.arb;
    assign if_ctrl   = if_obj.ctrl;
    assign if_data_a = if_obj.data_a;
    assign if_data_b = if_obj.data_b;

    // R6, R9: after the merge of a control read, the interface holds the stored word as read
    a_r6_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MRG && !cmd.dir_wr && cmd.acc_ctrl) |=> (if_ctrl == $past(rd_obj.ctrl)));

    // R4: a write transfer leaves the interface registers alone at merge
    a_r4_write_keeps_if: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MRG && cmd.dir_wr && !ifs_wr) |=> $stable(if_obj));

endmodule

// File: tb/sim_msg_xfer_engine.sv
module sim_msg_xfer_engine;

    localparam int NOBJ = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        ifs_wr = 1'b0;
    logic [2:0]  ifs_sel = '0;
    logic [31:0] ifs_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        busy;
    logic [31:0] if_mask, if_arb, if_data_a, if_data_b;
    logic [15:0] if_ctrl;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    msg_xfer_engine #(.NUM_OBJ(NOBJ)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .busy(busy), .ifs_wr(ifs_wr), .ifs_sel(ifs_sel),
        .ifs_wdata(ifs_wdata), .if_mask(if_mask), .if_arb(if_arb), .if_ctrl(if_ctrl),
        .if_data_a(if_data_a), .if_data_b(if_data_b)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural reference model
    logic [31:0] mo_mask [NOBJ];
    logic [31:0] mo_arb  [NOBJ];
    logic [15:0] mo_ctrl [NOBJ];
    logic [31:0] mo_da   [NOBJ];
    logic [31:0] mo_db   [NOBJ];
    logic [31:0] mi_mask, mi_arb, mi_da, mi_db;
    logic [15:0] mi_ctrl;
    logic [31:0] m_cmd;
    int          m_cnt;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_xfer();
        int n;
        n = int'(m_cmd[7:0]);
        if (m_cmd[23]) begin
            if (m_cmd[22]) mo_mask[n] = mi_mask;
            if (m_cmd[21]) mo_arb[n]  = mi_arb;
            if (m_cmd[20]) mo_ctrl[n] = mi_ctrl;
            if (m_cmd[17]) mo_da[n]   = mi_da;
            if (m_cmd[16]) mo_db[n]   = mi_db;
            if (m_cmd[18]) mo_ctrl[n] = mo_ctrl[n] | 16'h0500;
        end else begin
            if (m_cmd[22]) mi_mask = mo_mask[n];
            if (m_cmd[21]) mi_arb  = mo_arb[n];
            if (m_cmd[20]) mi_ctrl = mo_ctrl[n];
            if (m_cmd[17]) mi_da   = mo_da[n];
            if (m_cmd[16]) mi_db   = mo_db[n];
            if (m_cmd[19]) mo_ctrl[n][9]  = 1'b0;
            if (m_cmd[18]) mo_ctrl[n][10] = 1'b0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NOBJ; i++) begin
                mo_mask[i] = '0; mo_arb[i] = '0; mo_ctrl[i] = '0; mo_da[i] = '0; mo_db[i] = '0;
            end
            mi_mask = '0; mi_arb = '0; mi_ctrl = '0; mi_da = '0; mi_db = '0;
            m_cmd = '0;
            m_cnt = 0;
        end else begin
            if (m_cnt == 2) model_xfer();
            if (m_cnt != 0) begin
                m_cnt--;
            end else if (cmd_wr && (int'(cmd_wdata[7:0]) < NOBJ)) begin
                m_cmd = cmd_wdata & 32'h00FF_00FF;
                m_cnt = 3;
            end
            if (ifs_wr) begin
                case (ifs_sel)
                    3'd0: mi_mask = ifs_wdata;
                    3'd1: mi_arb  = ifs_wdata;
                    3'd2: mi_ctrl = ifs_wdata[15:0];
                    3'd3: mi_da   = ifs_wdata;
                    3'd4: mi_db   = ifs_wdata;
                    default: ;
                endcase
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 busy vs model", {31'd0, busy}, {31'd0, (m_cnt != 0)});
            check("R3 cmd_rdata vs model", cmd_rdata, m_cmd);
            check("R5 if_mask vs model", if_mask, mi_mask);
            check("R5 if_arb vs model", if_arb, mi_arb);
            check("R6 if_ctrl vs model", {16'd0, if_ctrl}, {16'd0, mi_ctrl});
            check("R4 if_data_a vs model", if_data_a, mi_da);
            check("R4 if_data_b vs model", if_data_b, mi_db);
        end
    end

    task automatic set_if(input logic [2:0] s, input logic [31:0] d);
        ifs_wr = 1'b1; ifs_sel = s; ifs_wdata = d;
        @(negedge clk);
        ifs_wr = 1'b0;
    endtask

    task automatic run_cmd(input logic [31:0] w, output int n);
        cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0;
        n = 0;
        while (busy && n < 10) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic zero_if();
        for (int s = 0; s < 5; s++) set_if(3'(s), 32'h0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        check("R1 cmd_rdata after reset", cmd_rdata, 32'd0);
        check("R1 if groups after reset", if_mask | if_arb | if_data_a | if_data_b | {16'd0, if_ctrl}, 32'd0);

        // load interface and write all groups to object 5
        set_if(3'd0, 32'h1234_5678);
        set_if(3'd1, 32'h8000_0ABC);
        set_if(3'd2, 32'h0000_0208);
        set_if(3'd3, 32'hDEAD_BEEF);
        set_if(3'd4, 32'h0102_0304);
        check("R10 if_data_b load", if_data_b, 32'h0102_0304);
        run_cmd(32'h00F3_0005, n);
        check("R2 busy length", n, 3);
        check("R2 cmd_rdata echo", cmd_rdata, 32'h00F3_0005);

        zero_if();
        set_if(3'd6, 32'hFFFF_FFFF);
        check("R10 bad select mask", if_mask, 32'h0);
        check("R10 bad select ctrl", {16'd0, if_ctrl}, 32'h0);
        check("R10 bad select data_a", if_data_a, 32'h0);

        // write with flag force only, then read with both clears
        run_cmd(32'h0084_0005, n);
        run_cmd(32'h001C_0005, n);
        check("R6 pre-clear read-back", {16'd0, if_ctrl}, 32'h0000_0708);
        check("R5 unselected mask kept", if_mask, 32'h0);
        check("R5 unselected data_a kept", if_data_a, 32'h0);
        run_cmd(32'h0010_0005, n);
        check("R6 flags cleared in object", {16'd0, if_ctrl}, 32'h0000_0108);
        run_cmd(32'h0020_0005, n);
        check("R9 arb visible when idle", if_arb, 32'h8000_0ABC);

        // write ctrl and data A with the ignored clear bit
        set_if(3'd3, 32'h1111_2222);
        set_if(3'd2, 32'h0000_0200);
        run_cmd(32'h009A_0005, n);
        zero_if();
        run_cmd(32'h0073_0005, n);
        check("R8 intp kept on write", {16'd0, if_ctrl}, 32'h0000_0200);
        check("R4 data_a written", if_data_a, 32'h1111_2222);
        check("R4 data_b untouched", if_data_b, 32'h0102_0304);
        check("R4 mask kept", if_mask, 32'h1234_5678);

        // forced flags override the interface control word
        set_if(3'd2, 32'h0);
        run_cmd(32'h0094_0005, n);
        run_cmd(32'h0010_0005, n);
        check("R7 forced flags", {16'd0, if_ctrl}, 32'h0000_0500);

        // second command while busy is dropped
        cmd_wr = 1'b1; cmd_wdata = 32'h0010_0005;
        @(negedge clk);
        cmd_wdata = 32'h0082_0006;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 busy command dropped", cmd_rdata, 32'h0010_0005);
        run_cmd(32'h0002_0006, n);
        check("R3 object 6 unchanged", if_data_a, 32'h0);

        // out-of-range object number
        cmd_wr = 1'b1; cmd_wdata = 32'h0010_0028;
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R3 bad number no busy", {31'd0, busy}, 32'd0);
        check("R3 bad number cmd kept", cmd_rdata, 32'h0002_0006);

        // reserved bits read back as zero
        set_if(3'd2, 32'h0000_FFFF);
        run_cmd(32'hAB13_AB07, n);
        check("R2 reserved bits zero", cmd_rdata, 32'h0013_0007);
        check("R1 object 7 reset value", {16'd0, if_ctrl}, 32'h0);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule